// File: doc/BRIEF.md
# Receive FIFO with Idle Timeout

This block is the receive-side byte buffer of a serial port. A receiver core delivers each byte as a one-cycle `rx_valid` strobe with `rx_data`. The bytes are kept in a 16-entry first-in first-out store. A CPU-side read port removes one byte per `rd_en` cycle, and `rd_data` always shows the oldest stored byte.

Around the store, the block keeps an occupancy count and derives several flags from it: empty, full, a sticky overflow flag, and a data-available flag whose level is chosen by a 2-bit code. An idle timer is clocked by a baud-rate tick input. It reports when bytes have been waiting with no new arrival for a programmed number of ticks. A flow-control output is driven from a second coded fill level, with selectable polarity. A software reset request flushes the store and holds the block in reset for three cycles.

Top module: `rx_fifo_timeout`

## Requirements
- R1: The store holds 16 bytes and returns them in arrival order. `count` rises by one for each accepted byte and falls by one for each accepted read. `full` is high exactly when `count` is 16. `count` and all flags take their new value at the clock edge that samples the stimulus.
- R2: `empty` is high exactly when `count` is 0. It drops when a byte is accepted. A read while empty is ignored, leaves `count` at 0 and shows `rd_data` as 0.
- R3: `avail_code` selects the data-available level: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. `avail` is high while `count` is at or above that level.
- R4: The idle counter restarts from zero on every accepted byte and advances on each `baud_tick` while the store is not empty. `tmo` sets on the tick at which the counter already equals `tmo_cmp`, which is the (`tmo_cmp`+1)-th tick after the last byte. Once set, `tmo` stays set.
- R5: A `tmo_cmp` of 0 keeps `tmo` from ever setting. Any `rd_en` cycle clears `tmo`, and this clear takes priority over a set in the same cycle.
- R6: A byte that arrives while `full` is high is discarded and the stored bytes are unchanged. `ovf` sets in that case and is cleared only by `ovf_clr`. A set takes priority over a clear in the same cycle.
- R7: A byte and a read accepted in the same cycle leave `count` unchanged.
- R8: `rts_code` uses the same 1/4/8/14 encoding as `avail_code`. The flow-control state is "ready" when `rts_auto_en` is 0 or when `count` is below the level. `rts_pin` equals the ready state when `rts_pol` is 1 and its inverse when `rts_pol` is 0.
- R9: At the edge that samples `sw_rst`, the store is emptied, `count` goes to 0 and the idle timer and `tmo` are cleared. `busy` is then high for the next 3 cycles. Bytes and reads presented in the `sw_rst` cycle or while `busy` is high are ignored and do not set `ovf`. `ovf` is not changed by `sw_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Byte strobe from the receiver core |
| rx_data | input | 8 | Received byte |
| rd_en | input | 1 | CPU read: remove the oldest byte |
| rd_data | output | 8 | Oldest stored byte, 0 when empty |
| baud_tick | input | 1 | One-cycle baud-rate tick for the idle timer |
| avail_code | input | 2 | Data-available level code |
| tmo_cmp | input | 9 | Idle timer compare value, 0 disables |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| sw_rst | input | 1 | Software flush request |
| rts_auto_en | input | 1 | Enable automatic flow control |
| rts_pol | input | 1 | 1: ready is driven high, 0: ready is driven low |
| rts_code | input | 2 | Flow-control level code |
| count | output | 5 | Number of stored bytes |
| empty | output | 1 | Store empty |
| full | output | 1 | Store full |
| avail | output | 1 | Count at or above the data-available level |
| ovf | output | 1 | Sticky overflow flag |
| tmo | output | 1 | Idle timeout flag |
| rts_pin | output | 1 | Flow-control output |
| busy | output | 1 | Software flush in progress |

## Verification
`rd_data` is combinational from the head of the store, so it shows the current oldest byte in the same cycle as the read request. `count`, `empty`, `full`, `avail`, `rts_pin`, `ovf`, `tmo` and `busy` all change at the first rising edge that samples the causing input, so each of them is due one edge after the stimulus. The bench drives inputs just after a falling edge and compares every output against a behavioural queue model shortly afterwards. It then advances the model by exactly one edge, so each result is checked in the cycle it is due and never later. Directed sequences cover the threshold codes, overflow at 16, the timeout at `tmo_cmp`+1 ticks and the three-cycle flush. A long pseudo-random run follows.

// File: rtl/rxf_pkg.sv
// Shared helpers for the receive FIFO.
// Assumes the coded levels are fixed at 1, 4, 8 and 14 bytes whatever the depth.
package rxf_pkg;

    localparam int LVL_W = 5;

    // Decode a 2-bit fill-level code into a byte count.
    function automatic logic [LVL_W-1:0] code_level(input logic [1:0] code);
        case (code)
            2'd0:    code_level = 5'd1;
            2'd1:    code_level = 5'd4;
            2'd2:    code_level = 5'd8;
            default: code_level = 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/rxf_store.sv
// Byte storage with wrapping read and write pointers.
// Assumes DEPTH is a power of two, so the pointers wrap without compare logic.
// Assumes the caller only writes when not full and only reads when not empty.
module rxf_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_ok,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_ok,
    input  logic          is_empty,
    output logic [DW-1:0] head
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Pointer advance on accepted writes and reads; flush returns both pointers to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Data array write; the array itself is not reset.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    // Oldest byte, forced to zero while nothing is stored.
    always_comb begin
        head = is_empty ? '0 : mem[rd_ptr];
    end

endmodule

// File: rtl/rxf_occupancy.sv
// Occupancy counter, empty/full/overflow flags and the software flush sequencer.
// Assumes sw_rst is a one-cycle request. The flush lasts RST_CYC cycles after it.
module rxf_occupancy #(
    parameter int DEPTH   = 16,
    parameter int RST_CYC = 3,
    localparam int CW     = $clog2(DEPTH) + 1,
    localparam int RW     = $clog2(RST_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic          ovf_clr,
    input  logic          sw_rst,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          flush,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          ovf,
    output logic          busy
);

    logic [RW-1:0] rst_cnt;

    // Status decode from the registered count and the flush counter.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        busy    = (rst_cnt != '0);
        flush   = sw_rst || busy;
        push_ok = push_req && !full && !flush;
        pop_ok  = pop_req && !empty && !flush;
    end

    // Flush sequencer: load on request, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      rst_cnt <= '0;
        else if (sw_rst) rst_cnt <= RW'(RST_CYC);
        else if (busy)   rst_cnt <= rst_cnt - 1'b1;
    end

    // Occupancy: up on accepted byte, down on accepted read, zero on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) count <= '0;
        else if (push_ok && !pop_ok) count <= count + 1'b1;
        else if (pop_ok && !push_ok) count <= count - 1'b1;
    end

    // Sticky overflow: a byte meeting a full store sets it, write-one clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ovf <= 1'b0;
        else if (push_req && full && !flush)     ovf <= 1'b1;
        else if (ovf_clr)                        ovf <= 1'b0;
    end

endmodule

// File: rtl/rxf_timeout.sv
// Idle timer on the baud tick. It reports bytes left waiting for cmp+1 ticks.
// Assumes baud_tick is a one-cycle pulse and that cmp is held steady while bytes wait.
module rxf_timeout #(
    parameter int TW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_ok,
    input  logic          rd_req,
    input  logic          baud_tick,
    input  logic          is_empty,
    input  logic [TW-1:0] cmp,
    output logic          tmo
);

    logic [TW-1:0] cnt;
    logic          hit;

    // Compare point: a tick that finds the counter at the compare value while bytes wait.
    always_comb begin
        hit = baud_tick && !push_ok && !is_empty && (cmp != '0) && (cnt == cmp);
    end

    // Tick counter: restart on new byte or empty store, stop at the compare value.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)            cnt <= '0;
        else if (push_ok || is_empty)   cnt <= '0;
        else if (baud_tick && cnt != cmp) cnt <= cnt + 1'b1;
    end

    // Timeout flag: a read clears it first, a hit sets it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) tmo <= 1'b0;
        else if (rd_req)     tmo <= 1'b0;
        else if (hit)        tmo <= 1'b1;
    end

endmodule

// File: rtl/rxf_levels.sv
// Coded-level comparators for the data-available flag and the flow-control output.
// Assumes both codes share the 1/4/8/14 encoding from the package.
module rxf_levels #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] count,
    input  logic [1:0]    avail_code,
    input  logic [1:0]    rts_code,
    input  logic          rts_auto_en,
    input  logic          rts_pol,
    output logic          avail,
    output logic          rts_pin
);

    logic [CW-1:0] avail_lvl;
    logic [CW-1:0] rts_lvl;
    logic          ready;

    // Level decode and threshold compares.
    always_comb begin
        avail_lvl = CW'(rxf_pkg::code_level(avail_code));
        rts_lvl   = CW'(rxf_pkg::code_level(rts_code));
        avail     = (count >= avail_lvl);
        ready     = !rts_auto_en || (count < rts_lvl);
        rts_pin   = rts_pol ? ready : !ready;
    end

endmodule

// File: rtl/rx_fifo_timeout.sv
// Receive FIFO top: storage, occupancy and flush, idle timer and level flags.
// Assumes rx_valid, rd_en, ovf_clr and sw_rst are synchronous one-cycle strobes.
module rx_fifo_timeout #(
    parameter int DW      = 8,
    parameter int DEPTH   = 16,
    parameter int TW      = 9,
    parameter int RST_CYC = 3,
    localparam int CW     = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          baud_tick,
    input  logic [1:0]    avail_code,
    input  logic [TW-1:0] tmo_cmp,
    input  logic          ovf_clr,
    input  logic          sw_rst,
    input  logic          rts_auto_en,
    input  logic          rts_pol,
    input  logic [1:0]    rts_code,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          avail,
    output logic          ovf,
    output logic          tmo,
    output logic          rts_pin,
    output logic          busy
);

    logic push_ok;
    logic pop_ok;
    logic flush;

    rxf_occupancy #(.DEPTH(DEPTH), .RST_CYC(RST_CYC)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (rx_valid),
        .pop_req  (rd_en),
        .ovf_clr  (ovf_clr),
        .sw_rst   (sw_rst),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .flush    (flush),
        .count    (count),
        .empty    (empty),
        .full     (full),
        .ovf      (ovf),
        .busy     (busy)
    );

    rxf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_ok    (push_ok),
        .wr_data  (rx_data),
        .rd_ok    (pop_ok),
        .is_empty (empty),
        .head     (rd_data)
    );

    rxf_timeout #(.TW(TW)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push_ok   (push_ok),
        .rd_req    (rd_en),
        .baud_tick (baud_tick),
        .is_empty  (empty),
        .cmp       (tmo_cmp),
        .tmo       (tmo)
    );

    rxf_levels #(.DEPTH(DEPTH)) u_lvl (
        .count       (count),
        .avail_code  (avail_code),
        .rts_code    (rts_code),
        .rts_auto_en (rts_auto_en),
        .rts_pol     (rts_pol),
        .avail       (avail),
        .rts_pin     (rts_pin)
    );

endmodule

// File: rtl/rxf_checker.sv
// Temporal checks on the receive FIFO ports, attached by bind.
module rxf_checker #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int TW    = 9,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rd_en,
    input logic          ovf_clr,
    input logic          sw_rst,
    input logic [TW-1:0] tmo_cmp,
    input logic [CW-1:0] count,
    input logic          full,
    input logic          empty,
    input logic          ovf,
    input logic          tmo,
    input logic          busy,
    input logic [DW-1:0] rd_data
);

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_rst && !busy) |=> ({1'b0, count} <= {1'b0, $past(count)} + 1'b1) &&
                               ({1'b0, count} + 1'b1 >= {1'b0, $past(count)}));

    p_empty_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !rx_valid) |=> empty && (rd_data == '0));

    p_tmo_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !tmo);

    p_tmo_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_cmp == '0 && !tmo) |=> !tmo);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rx_valid && !rd_en && !sw_rst && !busy) |=> full && ovf);

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> busy && (count == '0) && !tmo);

    p_busy_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> empty);

endmodule

bind rx_fifo_timeout rxf_checker #(.DW(DW), .DEPTH(DEPTH), .TW(TW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rd_en    (rd_en),
    .ovf_clr  (ovf_clr),
    .sw_rst   (sw_rst),
    .tmo_cmp  (tmo_cmp),
    .count    (count),
    .full     (full),
    .empty    (empty),
    .ovf      (ovf),
    .tmo      (tmo),
    .busy     (busy),
    .rd_data  (rd_data)
);

// File: tb/tb_rx_fifo_timeout.sv
module tb_rx_fifo_timeout;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid, rd_en, baud_tick, ovf_clr, sw_rst;
    logic [7:0] rx_data;
    logic [1:0] avail_code, rts_code;
    logic [8:0] tmo_cmp;
    logic       rts_auto_en, rts_pol;
    logic [7:0] rd_data;
    logic [4:0] count;
    logic       empty, full, avail, ovf, tmo, rts_pin, busy;

    always #5 clk = ~clk;

    rx_fifo_timeout dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rd_en(rd_en), .rd_data(rd_data), .baud_tick(baud_tick),
        .avail_code(avail_code), .tmo_cmp(tmo_cmp), .ovf_clr(ovf_clr),
        .sw_rst(sw_rst), .rts_auto_en(rts_auto_en), .rts_pol(rts_pol),
        .rts_code(rts_code), .count(count), .empty(empty), .full(full),
        .avail(avail), .ovf(ovf), .tmo(tmo), .rts_pin(rts_pin), .busy(busy)
    );

    // Behavioural reference state.
    logic [7:0] q[$];
    int  m_tcnt, m_busy, vectors, fails;
    bit  m_ovf, m_tmo;

    function automatic int lvl(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 14;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int  n;
        bit  ready;
        n     = q.size();
        ready = !rts_auto_en || (n < lvl(rts_code));
        vectors++;
        chk("R1 count", count, n);
        chk("R1 full", full, n == 16);
        chk("R2 empty", empty, n == 0);
        chk("R2 rd_data", rd_data, (n > 0) ? q[0] : 0);
        chk("R3 avail", avail, n >= lvl(avail_code));
        chk("R4 R5 tmo", tmo, m_tmo);
        chk("R6 ovf", ovf, m_ovf);
        chk("R8 rts_pin", rts_pin, rts_pol ? ready : !ready);
        chk("R9 busy", busy, m_busy != 0);
    endtask

    // Drive one cycle, check the outputs due now, then advance the model by one edge.
    task automatic cyc(input bit v, input logic [7:0] d, input bit rd,
                       input bit tk, input bit oc, input bit sr);
        int  n;
        bit  pu, po, clr;
        rx_valid = v; rx_data = d; rd_en = rd; baud_tick = tk; ovf_clr = oc; sw_rst = sr;
        #1;
        compare_all();
        n   = q.size();
        clr = sr || (m_busy != 0);
        if (v && n == 16 && !clr) m_ovf = 1;
        else if (oc)              m_ovf = 0;
        if (clr) begin
            q.delete();
            m_tcnt = 0;
            m_tmo  = 0;
            m_busy = sr ? 3 : m_busy - 1;
        end else begin
            pu = v && n < 16;
            po = rd && n > 0;
            if (rd) m_tmo = 0;
            else if (tk && !pu && n > 0 && tmo_cmp != 0 && m_tcnt == int'(tmo_cmp)) m_tmo = 1;
            if (pu || n == 0) m_tcnt = 0;
            else if (tk && m_tcnt != int'(tmo_cmp)) m_tcnt++;
            if (po) void'(q.pop_front());
            if (pu) q.push_back(d);
        end
        @(negedge clk);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cyc(0, 8'h00, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        rx_valid = 0; rx_data = 0; rd_en = 0; baud_tick = 0; ovf_clr = 0; sw_rst = 0;
        avail_code = 2'd1; rts_code = 2'd1; tmo_cmp = 9'd0; rts_auto_en = 0; rts_pol = 0;
        m_tcnt = 0; m_busy = 0; m_ovf = 0; m_tmo = 0; vectors = 0; fails = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 R2: reset state is empty with zero count.
        idle(2);

        // R1 R3: five bytes with level code 1 (4 bytes), then drain and read while empty (R2).
        for (int i = 0; i < 5; i++) cyc(1, 8'h10 + 8'(i), 0, 0, 0, 0);
        for (int i = 0; i < 7; i++) cyc(0, 8'h00, 1, 0, 0, 0);

        // R3: walk each threshold code through a fill to 16.
        for (int c = 0; c < 4; c++) begin
            avail_code = 2'(c);
            for (int i = 0; i < 16; i++) cyc(1, 8'(c * 16 + i), 0, 0, 0, 0);
            // R6: extra byte while full is discarded and sets ovf.
            cyc(1, 8'hEE, 0, 0, 0, 0);
            cyc(1, 8'hEF, 0, 0, 1, 0);
            cyc(0, 8'h00, 0, 0, 1, 0);
            for (int i = 0; i < 16; i++) cyc(0, 8'h00, 1, 0, 0, 0);
        end

        // R7: simultaneous byte and read on a partly filled store.
        for (int i = 0; i < 3; i++) cyc(1, 8'hA0 + 8'(i), 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(1, 8'hB0 + 8'(i), 1, 0, 0, 0);
        chk("R7 count held", count, 3);
        idle(1);
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 1, 0, 0, 0);

        // R4: compare 3, flag due on the fourth tick after the last byte.
        tmo_cmp = 9'd3;
        cyc(1, 8'h55, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) begin
            cyc(0, 8'h00, 0, 1, 0, 0);
            cyc(0, 8'h00, 0, 0, 0, 0);
        end
        chk("R4 tmo after cmp+1 ticks", tmo, 1);
        // R5: a read clears it, even with a tick in the same cycle.
        cyc(0, 8'h00, 1, 1, 0, 0);
        chk("R5 tmo cleared by read", tmo, 0);
        // R5: compare zero never sets.
        tmo_cmp = 9'd0;
        cyc(1, 8'h66, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) cyc(0, 8'h00, 0, 1, 0, 0);
        chk("R5 tmo disabled", tmo, 0);
        cyc(0, 8'h00, 1, 0, 0, 0);

        // R8: auto flow control at level 4 (code 1) and 14 (code 3), both polarities.
        rts_auto_en = 1;
        for (int p = 0; p < 2; p++) begin
            rts_pol = p[0];
            rts_code = 2'd1;
            for (int i = 0; i < 6; i++) cyc(1, 8'(i), 0, 0, 0, 0);
            rts_code = 2'd3;
            for (int i = 0; i < 10; i++) cyc(1, 8'(i), 0, 0, 0, 0);
            for (int i = 0; i < 16; i++) cyc(0, 8'h00, 1, 0, 0, 0);
        end

        // R9: flush a full store with ovf set; bytes during the flush are ignored.
        for (int i = 0; i < 17; i++) cyc(1, 8'h70 + 8'(i), 0, 0, 0, 0);
        cyc(1, 8'h99, 1, 0, 0, 1);
        for (int i = 0; i < 4; i++) cyc(1, 8'h90 + 8'(i), 1, 0, 0, 0);
        cyc(0, 8'h00, 0, 0, 1, 0);
        idle(2);

        // Mixed pseudo-random traffic across all controls.
        tmo_cmp = 9'd5;
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) begin
                avail_code  = 2'($urandom_range(0, 3));
                rts_code    = 2'($urandom_range(0, 3));
                rts_pol     = 1'($urandom_range(0, 1));
                rts_auto_en = 1'($urandom_range(0, 1));
            end
            cyc(($urandom_range(0, 99) < 45), 8'($urandom),
                ($urandom_range(0, 99) < 35), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 49) == 0), ($urandom_range(0, 299) == 0));
        end
        finish_run();
    end

endmodule